// File: doc/BRIEF.md
# Real-Time Clock Register and Interrupt Unit

This block is the register side of a battery-backed clock/calendar. Software reaches it through two byte ports that share one bus. The index port selects one of up to 128 internal bytes. Bit 7 of the index port also drives a mask for the non-maskable interrupt. The data port then reads or writes the selected byte. The internal bytes are:

- the time and date counters;
- three alarm comparands;
- four control/status registers;
- a bank of general-purpose storage.

A free-running prescaler counts pulses of the 32.768 kHz time base. Each time the prescaler wraps, the time advances by one second, with full carry through the calendar. A 4-bit selector taps the same prescaler to raise a periodic event. Periodic, alarm and update-ended events are latched in a status register that clears when read. The interrupt request is the OR of every latched event whose enable bit is set. Time bytes are held internally in binary. They are converted to or from packed BCD at the data port when the format bit selects BCD.

Top module: `clockcal_top`

## Requirements
- R1: After reset, nmiMask is 1 and irqOut is 0. Reading the index port returns 0x80. Reading index 0xC returns 0x00 and reading index 0xD returns 0x80.
- R2: A write to the index port (portSel=0) sets nmiMask from bit 7 and the index from bits 6:0. A read of the index port returns {nmiMask, index}.
- R3: Indices 0x0E to 0x0E+RAM_BYTES-1 are general storage. Each byte reads back the last value written to it.
- R4: The time layout is: index 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 date, 8 month, 9 year. Index 0xB bit 2 selects the data format: 1 = binary, 0 = packed BCD. Writes and reads of these bytes use the format active at the time of the access.
- R5: Seconds advance once every 2^DIV_BITS base ticks. The carry runs seconds 59→0, minutes 59→0 and hours 23→0. Day of week wraps 7→1.
- R6: The date wraps to 1 after the last day of its month, and the month advances. April, June, September and November have 30 days. February has 29 days when year mod 4 = 0 and 28 days otherwise. Month 12 wraps to 1 and the year wraps 99→0.
- R7: With rate value n = index 0xA bits 3:0 and n ≠ 0, index 0xC bit 6 is set on each tick that makes the prescaler a multiple of 2^(n-1). A period longer than one second is clamped to one second. With n = 0, bit 6 is never set.
- R8: Index 0xC bit 5 is set on a second advance whose new seconds, minutes and hours equal the three alarm bytes.
- R9: Index 0xC bit 4 is set on every second advance.
- R10: The enable bits in index 0xB are bit 6 (periodic), bit 5 (alarm) and bit 4 (update). irqOut is 1 exactly when a set flag in index 0xC has its enable set. Index 0xC bit 7 reads as irqOut.
- R11: A data read of index 0xC clears its flags from the next cycle on, and with them irqOut. An event in the same cycle as the read still sets its flag.
- R12: Writes to indices 0xC and 0xD have no effect. Index 0xD always reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | One-cycle pulse per period of the 32.768 kHz time base |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe; read side effects take place at the clock edge |
| portSel | input | 1 | 0 selects the index port, 1 selects the data port |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data for the selected port, combinational |
| nmiMask | output | 1 | NMI mask, 1 = masked |
| irqOut | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples it in the same cycle as the read strobe, half a clock after driving the strobe. A register write, a flag clear or a one-second advance takes effect at the edge that closes the write, read or tick cycle. The bench therefore observes the result from the following cycle on.

The bench drives every base tick itself and keeps its own prescaler phase. This lets it place each check exactly one tick before and one tick after the edge where a periodic or second event is due. It uses this to sweep all fifteen rate values and the calendar boundaries.

// File: rtl/clockcal_pkg.sv
package clockcal_pkg;
  localparam logic [6:0] IX_SEC    = 7'h00;
  localparam logic [6:0] IX_ASEC   = 7'h01;
  localparam logic [6:0] IX_MIN    = 7'h02;
  localparam logic [6:0] IX_AMIN   = 7'h03;
  localparam logic [6:0] IX_HR     = 7'h04;
  localparam logic [6:0] IX_AHR    = 7'h05;
  localparam logic [6:0] IX_DOW    = 7'h06;
  localparam logic [6:0] IX_DATE   = 7'h07;
  localparam logic [6:0] IX_MON    = 7'h08;
  localparam logic [6:0] IX_YR     = 7'h09;
  localparam logic [6:0] IX_CTLA   = 7'h0A;
  localparam logic [6:0] IX_CTLB   = 7'h0B;
  localparam logic [6:0] IX_FLAGS  = 7'h0C;
  localparam logic [6:0] IX_VALID  = 7'h0D;
  localparam int         RAM_BASE  = 14;

  // strobes from control to datapath
  typedef struct packed {
    logic wrIndex;
    logic wrReg;
    logic rdReg;
    logic secTick;
    logic perTick;
  } ccStrobe_t;

  function automatic logic [7:0] toBcd(input logic [7:0] v);
    logic [7:0] t, o;
    t = v / 8'd10;
    o = v % 8'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [7:0] fromBcd(input logic [7:0] b);
    return {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/clockcal_ctrl.sv
module clockcal_ctrl
  import clockcal_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       portSel,
  input  logic [3:0] rateSel,
  output ccStrobe_t  st
);
  localparam logic [DIV_BITS-1:0] ONE = DIV_BITS'(1);

  logic [DIV_BITS-1:0] divCnt, divNext, perMask;
  logic [31:0]         fullMask;

  assign divNext  = divCnt + ONE;
  assign fullMask = (32'd1 << (rateSel - 4'd1)) - 32'd1;
  assign perMask  = fullMask[DIV_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)         divCnt <= '0;
    else if (baseTick) divCnt <= divNext;
  end

  always_comb begin
    st.wrIndex = busWr && !portSel;
    st.wrReg   = busWr && portSel;
    st.rdReg   = busRd && portSel;
    st.secTick = baseTick && (divNext == '0);
    st.perTick = baseTick && (rateSel != 4'd0) && ((divNext & perMask) == '0);
  end

  p_per_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel == 4'd0) |-> !st.perTick);
  p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.secTick |=> (divCnt == '0));
endmodule

// File: rtl/clockcal_datapath.sv
module clockcal_datapath
  import clockcal_pkg::*;
#(
  parameter int RAM_BYTES = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  ccStrobe_t  st,
  input  logic       portSel,
  input  logic [7:0] wData,
  output logic [7:0] rData,
  output logic [3:0] rateSel,
  output logic       nmiMask,
  output logic       irqOut
);
  localparam int         RAM_AW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
  localparam logic [6:0] RAM_LO = 7'(RAM_BASE);
  localparam logic [6:0] RAM_HI = 7'(RAM_BASE + RAM_BYTES - 1);

  logic [6:0] index;
  logic [7:0] sec, min, hr, dow, date, mon, yr, aSec, aMin, aHr, ctlA, ctlB;
  logic [7:0] nSec, nMin, nHr, nDow, nDate, nMon, nYr, wVal, dataVal;
  logic       pf, af, uf, clrFlags, alarmHit, binMode, inRam;
  logic [6:0] ramOff;
  logic [7:0] ram [RAM_BYTES];

  assign binMode  = ctlB[2];
  assign rateSel  = ctlA[3:0];
  assign wVal     = binMode ? wData : fromBcd(wData);
  assign clrFlags = st.rdReg && (index == IX_FLAGS);
  assign irqOut   = (pf && ctlB[6]) || (af && ctlB[5]) || (uf && ctlB[4]);
  assign inRam    = (index >= RAM_LO) && (index <= RAM_HI);
  assign ramOff   = index - RAM_LO;

  // next-second carry chain
  always_comb begin
    nSec = sec; nMin = min; nHr = hr; nDow = dow; nDate = date; nMon = mon; nYr = yr;
    if (sec >= 8'd59) begin
      nSec = 8'd0;
      if (min >= 8'd59) begin
        nMin = 8'd0;
        if (hr >= 8'd23) begin
          nHr  = 8'd0;
          nDow = (dow >= 8'd7) ? 8'd1 : dow + 8'd1;
          if (date >= monthDays(mon, yr)) begin
            nDate = 8'd1;
            if (mon >= 8'd12) begin
              nMon = 8'd1;
              nYr  = (yr >= 8'd99) ? 8'd0 : yr + 8'd1;
            end else nMon = mon + 8'd1;
          end else nDate = date + 8'd1;
        end else nHr = hr + 8'd1;
      end else nMin = min + 8'd1;
    end else nSec = sec + 8'd1;
    alarmHit = st.secTick && (nSec == aSec) && (nMin == aMin) && (nHr == aHr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      index <= '0; nmiMask <= 1'b1;
      sec <= 8'd0; min <= 8'd0; hr <= 8'd0; dow <= 8'd1; date <= 8'd1; mon <= 8'd1; yr <= 8'd0;
      aSec <= 8'd0; aMin <= 8'd0; aHr <= 8'd0; ctlA <= 8'd0; ctlB <= 8'd0;
      pf <= 1'b0; af <= 1'b0; uf <= 1'b0;
    end else begin
      if (st.wrIndex) begin
        nmiMask <= wData[7];
        index   <= wData[6:0];
      end
      if (st.secTick) begin
        sec <= nSec; min <= nMin; hr <= nHr; dow <= nDow; date <= nDate; mon <= nMon; yr <= nYr;
      end
      if (st.wrReg) begin
        case (index)
          IX_SEC:  sec  <= wVal;
          IX_ASEC: aSec <= wVal;
          IX_MIN:  min  <= wVal;
          IX_AMIN: aMin <= wVal;
          IX_HR:   hr   <= wVal;
          IX_AHR:  aHr  <= wVal;
          IX_DOW:  dow  <= wVal;
          IX_DATE: date <= wVal;
          IX_MON:  mon  <= wVal;
          IX_YR:   yr   <= wVal;
          IX_CTLA: ctlA <= wData;
          IX_CTLB: ctlB <= wData;
          default: ;
        endcase
      end
      pf <= (pf && !clrFlags) || st.perTick;
      af <= (af && !clrFlags) || alarmHit;
      uf <= (uf && !clrFlags) || st.secTick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= 8'd0;
    end else if (st.wrReg && inRam) begin
      ram[ramOff[RAM_AW-1:0]] <= wData;
    end
  end

  always_comb begin
    case (index)
      IX_SEC:   dataVal = binMode ? sec  : toBcd(sec);
      IX_ASEC:  dataVal = binMode ? aSec : toBcd(aSec);
      IX_MIN:   dataVal = binMode ? min  : toBcd(min);
      IX_AMIN:  dataVal = binMode ? aMin : toBcd(aMin);
      IX_HR:    dataVal = binMode ? hr   : toBcd(hr);
      IX_AHR:   dataVal = binMode ? aHr  : toBcd(aHr);
      IX_DOW:   dataVal = binMode ? dow  : toBcd(dow);
      IX_DATE:  dataVal = binMode ? date : toBcd(date);
      IX_MON:   dataVal = binMode ? mon  : toBcd(mon);
      IX_YR:    dataVal = binMode ? yr   : toBcd(yr);
      IX_CTLA:  dataVal = ctlA;
      IX_CTLB:  dataVal = ctlB;
      IX_FLAGS: dataVal = {irqOut, pf, af, uf, 4'd0};
      IX_VALID: dataVal = 8'h80;
      default:  dataVal = inRam ? ram[ramOff[RAM_AW-1:0]] : 8'hFF;
    endcase
    rData = portSel ? dataVal : {nmiMask, index};
  end

  p_nmi_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.wrIndex |=> (nmiMask == $past(wData[7])));
  p_sec_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.secTick && !st.wrReg && sec < 8'd59) |=> (sec == $past(sec) + 8'd1));
  p_uf_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.secTick |=> uf);
  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlags && !st.perTick && !st.secTick) |=> (!pf && !af && !uf && !irqOut));
endmodule

// File: rtl/clockcal_top.sv
module clockcal_top
  import clockcal_pkg::*;
#(
  parameter int DIV_BITS  = 15,
  parameter int RAM_BYTES = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       portSel,
  input  logic [7:0] busWData,
  output logic [7:0] busRData,
  output logic       nmiMask,
  output logic       irqOut
);
  ccStrobe_t  st;
  logic [3:0] rateSel;

  clockcal_ctrl #(.DIV_BITS(DIV_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .busWr(busWr), .busRd(busRd),
    .portSel(portSel), .rateSel(rateSel), .st(st)
  );

  clockcal_datapath #(.RAM_BYTES(RAM_BYTES)) uData (
    .clk(clk), .rstN(rstN), .st(st), .portSel(portSel), .wData(busWData),
    .rData(busRData), .rateSel(rateSel), .nmiMask(nmiMask), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_clockcal_top.sv
module sim_clockcal_top;
  localparam int DIVB  = 4;
  localparam int SECT  = 1 << DIVB;
  localparam int RAMN  = 50;

  logic clk = 1'b0, rstN = 1'b0, baseTick = 1'b0, busWr = 1'b0, busRd = 1'b0, portSel = 1'b0;
  logic [7:0] busWData = 8'd0, busRData;
  logic nmiMask, irqOut;
  int checks = 0, failures = 0, phase = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  clockcal_top #(.DIV_BITS(DIVB), .RAM_BYTES(RAMN)) u0 (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .busWr(busWr), .busRd(busRd),
    .portSel(portSel), .busWData(busWData), .busRData(busRData),
    .nmiMask(nmiMask), .irqOut(irqOut)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic sel, input logic [7:0] d);
    @(negedge clk); busWr = 1'b1; portSel = sel; busWData = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic sel, output logic [7:0] d);
    @(negedge clk); busRd = 1'b1; portSel = sel;
    #1 d = busRData;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic regWrite(input logic [6:0] idx, input logic [7:0] d);
    busWrite(1'b0, {1'b0, idx});
    busWrite(1'b1, d);
  endtask

  task automatic regRead(input logic [6:0] idx, output logic [7:0] d);
    busWrite(1'b0, {1'b0, idx});
    busRead(1'b1, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); baseTick = 1'b1;
      @(negedge clk); baseTick = 1'b0;
      phase = (phase + 1) % SECT;
    end
  endtask

  task automatic nextSecond();
    ticks(SECT - phase);
  endtask

  task automatic setTime(input int h, input int m, input int s, input int dt, input int mo, input int y);
    regWrite(7'h04, 8'(h)); regWrite(7'h02, 8'(m)); regWrite(7'h00, 8'(s));
    regWrite(7'h07, 8'(dt)); regWrite(7'h08, 8'(mo)); regWrite(7'h09, 8'(y));
  endtask

  task automatic expectReg(input string req, input logic [6:0] idx, input int exp);
    logic [7:0] r;
    regRead(idx, r);
    check(req, r, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 nmiMask", nmiMask, 1);
    check("R1 irqOut", irqOut, 0);
    busRead(1'b0, v); check("R1 index port", v, 8'h80);
    expectReg("R1 flags", 7'h0C, 8'h00);
    expectReg("R1 valid", 7'h0D, 8'h80);

    // R2 index port
    busWrite(1'b0, 8'h8E);
    check("R2 mask set", nmiMask, 1);
    busRead(1'b0, v); check("R2 readback", v, 8'h8E);
    busWrite(1'b0, 8'h0E);
    check("R2 mask clear", nmiMask, 0);

    // R3 storage sweep
    for (int i = 0; i < RAMN; i++) regWrite(7'(14 + i), 8'(i) ^ 8'h5A);
    for (int i = 0; i < RAMN; i++) expectReg("R3 ram", 7'(14 + i), 8'(i) ^ 8'h5A);

    // R5 R6 calendar in binary
    regWrite(7'h0B, 8'h04);
    regWrite(7'h0A, 8'h00);
    setTime(23, 59, 58, 28, 2, 3);
    regWrite(7'h06, 8'd7);
    nextSecond();
    expectReg("R5 sec step", 7'h00, 59);
    expectReg("R5 min hold", 7'h02, 59);
    nextSecond();
    expectReg("R5 sec wrap", 7'h00, 0);
    expectReg("R5 min wrap", 7'h02, 0);
    expectReg("R5 hr wrap", 7'h04, 0);
    expectReg("R5 dow wrap", 7'h06, 1);
    expectReg("R6 feb28 date", 7'h07, 1);
    expectReg("R6 feb28 month", 7'h08, 3);
    setTime(23, 59, 59, 28, 2, 4);
    nextSecond();
    expectReg("R6 leap date", 7'h07, 29);
    expectReg("R6 leap month", 7'h08, 2);
    setTime(23, 59, 59, 30, 4, 10);
    nextSecond();
    expectReg("R6 apr date", 7'h07, 1);
    expectReg("R6 apr month", 7'h08, 5);
    setTime(23, 59, 59, 31, 12, 99);
    nextSecond();
    expectReg("R6 dec month", 7'h08, 1);
    expectReg("R6 year wrap", 7'h09, 0);
    setTime(5, 10, 59, 3, 3, 3);
    nextSecond();
    expectReg("R5 min carry", 7'h02, 11);
    expectReg("R5 hr hold", 7'h04, 5);

    // R4 format
    regWrite(7'h0B, 8'h00);
    regWrite(7'h00, 8'h37);
    expectReg("R4 bcd read", 7'h00, 8'h37);
    regWrite(7'h0B, 8'h04);
    expectReg("R4 bin view", 7'h00, 37);
    regWrite(7'h0B, 8'h00);
    regWrite(7'h00, 8'h09);
    nextSecond();
    expectReg("R4 bcd advance", 7'h00, 8'h10);

    // R7 periodic sweep
    regWrite(7'h0B, 8'h04);
    for (int n = 1; n < 16; n++) begin
      int p, k;
      p = (n - 1 >= DIVB) ? SECT : (1 << (n - 1));
      regWrite(7'h0A, 8'(n));
      regRead(7'h0C, v);
      k = p - (phase % p);
      ticks(k - 1);
      regRead(7'h0C, v); check("R7 before period", v[6], 0);
      ticks(1);
      regRead(7'h0C, v); check("R7 at period", v[6], 1);
    end
    regWrite(7'h0A, 8'h00);
    regRead(7'h0C, v);
    ticks(40);
    regRead(7'h0C, v); check("R7 rate zero", v[6], 0);

    // R8 R9 R10 R11 alarm and interrupt
    setTime(2, 1, 0, 1, 1, 1);
    regWrite(7'h01, 8'd1); regWrite(7'h03, 8'd1); regWrite(7'h05, 8'd2);
    regRead(7'h0C, v);
    nextSecond();
    @(negedge clk);
    check("R10 disabled no irq", irqOut, 0);
    regWrite(7'h0B, 8'h24);
    check("R10 alarm irq", irqOut, 1);
    regRead(7'h0C, v); check("R8 R9 R10 flags", v, 8'hB0);
    check("R11 irq cleared", irqOut, 0);
    expectReg("R11 flags cleared", 7'h0C, 8'h00);
    regWrite(7'h0B, 8'h14);
    nextSecond();
    @(negedge clk);
    check("R9 update irq", irqOut, 1);
    regRead(7'h0C, v); check("R9 no alarm", v, 8'h90);

    // R12 read-only
    regWrite(7'h0B, 8'h04);
    regWrite(7'h0D, 8'h00);
    expectReg("R12 valid", 7'h0D, 8'h80);
    regWrite(7'h0C, 8'h70);
    expectReg("R12 flags write", 7'h0C, 8'h00);
    check("R12 irq", irqOut, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule